// File: doc/BRIEF.md
# Power-Up Sequencer and Fault Supervisor

This block is the digital supervisor of a two-channel step-down regulator controller. Channel A is the lower-voltage output and channel B the higher-voltage one. The block reads a small set of level inputs:

- an active-low shutdown input;
- two on inputs;
- a static sequence-select strap;
- a comparator flag showing that a timing capacitor has charged past the reference;
- per-channel comparator flags for reset threshold, under-voltage and over-voltage;
- over-temperature and power-on-reset flags.

From these it decides the operating mode and which channels run. It times the power-good release and the under-voltage arming window in switching cycles. It latches the channels off on a protection fault.

All asynchronous flags pass through two-flop synchronizers before use. A one-clock pulse per switching cycle (`tick`) is the only time base for the delays, so the cycle counts do not depend on the system clock rate.

Power-good is the active-low reset output `sysResetN`. It is released only after the delay count has finished and the monitored channels report that they are above their reset threshold. A drop of a monitored flag pulls it low again without restarting the count.

Top module: `psu_supervisor`

## Requirements
- R1: `opMode` is 2'b00 (shutdown) while `shdnN` is low, 2'b01 (standby) while `shdnN` is high and no channel is enabled, and 2'b10 (run) while any bit of `chEn` is set. Bit 0 of `chEn` is channel A and bit 1 is channel B.
- R2: While `otFlag` is high the mode is shutdown and both channel enables are low, regardless of the other inputs.
- R3: With `seqSel` 2'b00 or 2'b11 (independent start), `chEn[0]` follows `onA` and `chEn[1]` follows `onB`.
- R4: With `seqSel` 2'b01, a rising edge of `onA` seen while active enables channel B. Channel A is enabled once `capAbove` is seen high after that. `onA` going low disables both. An `onA` that is already high when the block leaves shutdown starts nothing.
- R5: With `seqSel` 2'b10, the order is swapped: the `onA` rising edge enables channel A, and `capAbove` then enables channel B. `onB` has no effect in this mode.
- R6: `sysResetN` stays low until PG_DELAY ticks (default 32000) have passed since the most recent rising edge of any channel enable.
- R7: In independent mode `sysResetN` reflects only channel A's `rstOkFlag[0]`. It is low whenever channel A is not enabled, including when only channel B runs.
- R8: In either cross-triggered mode, `sysResetN` is high only while both channels are enabled and both `rstOkFlag` bits are high.
- R9: A fall of a monitored `rstOkFlag` bit drives `sysResetN` low within three clocks, with no count. Its return releases `sysResetN` within three clocks without a new delay.
- R10: `uvFlag[n]` has no effect until UV_ARM ticks (default 6144) have passed with channel n enabled. After that, it latches both channels off with `latchedOff` high and `lowSideForce` low. A flag on a channel that is not enabled is ignored.
- R11: `ovFlag` on either channel, while the block is active, latches both channels off and sets `lowSideForce`. The mode then reads standby.
- R12: The fault latch persists after the fault flag clears. It is cleared only by `shdnN` low, by a fall of `onA`, or by `porFlag`. `porFlag` also forces shutdown while high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset of the logic |
| shdnN | input | 1 | Active-low shutdown request |
| onA | input | 1 | Channel A on input (also the start/clear input in cross modes) |
| onB | input | 1 | Channel B on input (independent mode only) |
| seqSel | input | 2 | Static start-order strap: 00/11 independent, 01 B first, 10 A first |
| capAbove | input | 1 | Timing capacitor above reference |
| tick | input | 1 | One-clock pulse per switching cycle |
| rstOkFlag | input | 2 | Channel output above its reset threshold |
| uvFlag | input | 2 | Channel output under-voltage |
| ovFlag | input | 2 | Channel output over-voltage |
| otFlag | input | 1 | Over-temperature |
| porFlag | input | 1 | Input supply power-on reset |
| opMode | output | 2 | 00 shutdown, 01 standby, 10 run |
| chEn | output | 2 | Channel enables, bit 0 = A, bit 1 = B |
| sysResetN | output | 1 | Active-low reset / power-good |
| latchedOff | output | 1 | Fault latch holding both channels off |
| lowSideForce | output | 1 | Force low-side drivers on (over-voltage latch) |

## Verification
Mode decoding and channel enables are swept over every combination of shutdown, both on inputs and over-temperature in independent mode. This separates the shutdown-over-everything priority from the per-channel enable mapping. Both cross-triggered orders are driven through edge, capacitor and release steps, plus a level-high on input carried out of shutdown. These steps tell edge detection apart from level following, and show which channel starts first. Power-good is probed just before and just after its tick count, and with each reset-threshold flag dropped in turn, which exposes the monitored-channel selection. Under-voltage pulses before and after the arming window, and on a disabled channel, separate the arming from the fault path. Each fault latch is then cleared by each of its three release causes.

// File: rtl/psup_pkg.sv
package psup_pkg;

  localparam int NCH = 2;

  typedef enum logic [1:0] {
    MODE_SHUT    = 2'b00,
    MODE_STANDBY = 2'b01,
    MODE_RUN     = 2'b10
  } opMode_e;

  typedef enum logic [1:0] {
    SEQ_INDEP     = 2'b00,
    SEQ_B_FIRST   = 2'b01,
    SEQ_A_FIRST   = 2'b10,
    SEQ_INDEP_ALT = 2'b11
  } seq_e;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic           pgRestart;
    logic [NCH-1:0] uvRun;
  } dpCtl_t;

endpackage

// File: rtl/psup_sync.sv
module psup_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= dIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign qOut = stage[STAGES-1];

endmodule

// File: rtl/psup_timers.sv
module psup_timers
  import psup_pkg::*;
#(
  parameter int PG_DELAY = 32000,
  parameter int UV_ARM   = 6144
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           tick,
  input  dpCtl_t         ctl,
  output logic           pgDone,
  output logic [NCH-1:0] uvArmed
);

  localparam int PGW = $clog2(PG_DELAY + 1);
  localparam int UVW = $clog2(UV_ARM + 1);
  localparam logic [PGW-1:0] PG_MAX = PGW'(PG_DELAY);
  localparam logic [UVW-1:0] UV_MAX = UVW'(UV_ARM);

  logic [PGW-1:0] pgCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       pgCnt <= '0;
    else if (ctl.pgRestart)          pgCnt <= '0;
    else if (tick && pgCnt != PG_MAX) pgCnt <= pgCnt + 1'b1;
  end

  assign pgDone = (pgCnt == PG_MAX);

  // R6: the power-good count can only complete on a switching-cycle tick
  p_pg_on_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pgDone) |-> $past(tick));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_uv
    logic [UVW-1:0] uvCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          uvCnt <= '0;
      else if (!ctl.uvRun[ch])            uvCnt <= '0;
      else if (tick && uvCnt != UV_MAX)   uvCnt <= uvCnt + 1'b1;
    end

    assign uvArmed[ch] = (uvCnt == UV_MAX);

    // R10: arming completes on a tick and is dropped once the channel stops
    p_uv_arm_tick_r10: assert property (@(posedge clk) disable iff (!rstN)
      $rose(uvArmed[ch]) |-> $past(tick));
    p_uv_disarm_r10: assert property (@(posedge clk) disable iff (!rstN)
      !ctl.uvRun[ch] |=> !uvArmed[ch]);
  end

endmodule

// File: rtl/psup_ctrl.sv
module psup_ctrl
  import psup_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           shdnS,
  input  logic           onAS,
  input  logic           onBS,
  input  logic           capS,
  input  logic           otS,
  input  logic           porS,
  input  logic [1:0]     seqSel,
  input  logic [NCH-1:0] rstOkS,
  input  logic [NCH-1:0] uvS,
  input  logic [NCH-1:0] ovS,
  input  logic           pgDone,
  input  logic [NCH-1:0] uvArmed,
  output dpCtl_t         ctl,
  output logic [1:0]     opMode,
  output logic [NCH-1:0] chEn,
  output logic           sysResetN,
  output logic           latchedOff,
  output logic           lowSideForce
);

  logic           onAPrev, startSeq, capSeen;
  logic           latchReg, lsReg, rstReg;
  logic [NCH-1:0] enReg;
  opMode_e        modeReg;

  logic           active, crossMode, onARise, onAFall, clearFault;
  logic           startNext, capNext, ovHit, uvHit, latchNext, lsNext;
  logic           monOk, rstNext;
  logic [NCH-1:0] enReq, enNext;
  opMode_e        modeNext;

  always_comb begin
    active    = shdnS & ~otS & ~porS;
    crossMode = (seqSel == SEQ_B_FIRST) || (seqSel == SEQ_A_FIRST);
    onARise   = onAS & ~onAPrev;
    onAFall   = ~onAS & onAPrev;

    // cross-triggered start: armed by an edge, held by the level
    if (!active || !onAS || !crossMode) startNext = 1'b0;
    else if (onARise)                   startNext = 1'b1;
    else                                startNext = startSeq;
    capNext = startNext & (capSeen | capS);

    unique case (seqSel)
      SEQ_B_FIRST: enReq = {startNext, startNext & capNext};
      SEQ_A_FIRST: enReq = {startNext & capNext, startNext};
      default:     enReq = {onBS, onAS};
    endcase

    // fault latch: release causes win over new faults in the same cycle
    clearFault = ~shdnS | porS | onAFall;
    ovHit      = active & (|ovS);
    uvHit      = active & (|(uvS & uvArmed & enReg));
    latchNext  = clearFault ? 1'b0 : (latchReg | ovHit | uvHit);
    lsNext     = clearFault ? 1'b0 : (lsReg | ovHit);

    enNext = (active && !latchNext) ? enReq : '0;

    if (!active)       modeNext = MODE_SHUT;
    else if (|enNext)  modeNext = MODE_RUN;
    else               modeNext = MODE_STANDBY;

    // power-good monitoring set depends on the start order
    if (crossMode) monOk = (&enReg) & (&rstOkS);
    else           monOk = enReg[0] & rstOkS[0];
    rstNext = active & ~latchReg & pgDone & monOk;

    ctl.pgRestart = (enNext == '0) || ((enNext & ~enReg) != '0);
    ctl.uvRun     = enReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onAPrev  <= 1'b0;
      startSeq <= 1'b0;
      capSeen  <= 1'b0;
      latchReg <= 1'b0;
      lsReg    <= 1'b0;
      enReg    <= '0;
      modeReg  <= MODE_SHUT;
      rstReg   <= 1'b0;
    end else begin
      onAPrev  <= onAS;
      startSeq <= startNext;
      capSeen  <= capNext;
      latchReg <= latchNext;
      lsReg    <= lsNext;
      enReg    <= enNext;
      modeReg  <= modeNext;
      rstReg   <= rstNext;
    end
  end

  assign opMode       = modeReg;
  assign chEn         = enReg;
  assign sysResetN    = rstReg;
  assign latchedOff   = latchReg;
  assign lowSideForce = lsReg;

  // R1: shutdown never coexists with an enabled channel
  p_shut_no_en_r1: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg == MODE_SHUT) |-> (enReg == '0));
  // R11: a latched fault keeps both channels off
  p_latch_kills_en_r11: assert property (@(posedge clk) disable iff (!rstN)
    latchReg |-> (enReg == '0));
  // R11: low-side forcing only under a latched fault
  p_ls_needs_latch_r11: assert property (@(posedge clk) disable iff (!rstN)
    lsReg |-> latchReg);
  // R6: reset release only after the delay count finished
  p_reset_after_pg_r6: assert property (@(posedge clk) disable iff (!rstN)
    rstReg |-> $past(pgDone));
  // R4: with B first, A never runs without B
  p_b_first_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(seqSel) == SEQ_B_FIRST && enReg[0]) |-> enReg[1]);
  // R5: with A first, B never runs without A
  p_a_first_order_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(seqSel) == SEQ_A_FIRST && enReg[1]) |-> enReg[0]);

endmodule

// File: rtl/psu_supervisor.sv
module psu_supervisor
  import psup_pkg::*;
#(
  parameter int PG_DELAY    = 32000,
  parameter int UV_ARM      = 6144,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       shdnN,
  input  logic       onA,
  input  logic       onB,
  input  logic [1:0] seqSel,
  input  logic       capAbove,
  input  logic       tick,
  input  logic [1:0] rstOkFlag,
  input  logic [1:0] uvFlag,
  input  logic [1:0] ovFlag,
  input  logic       otFlag,
  input  logic       porFlag,
  output logic [1:0] opMode,
  output logic [1:0] chEn,
  output logic       sysResetN,
  output logic       latchedOff,
  output logic       lowSideForce
);

  localparam int SW = 6 + 3 * NCH;

  logic [SW-1:0]  rawIn, syncIn;
  logic           shdnS, onAS, onBS, capS, otS, porS;
  logic [NCH-1:0] rstOkS, uvS, ovS, uvArmed;
  logic           pgDone;
  dpCtl_t         ctl;

  assign rawIn = {shdnN, onA, onB, capAbove, otFlag, porFlag, rstOkFlag, uvFlag, ovFlag};

  psup_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (rawIn),
    .qOut (syncIn)
  );

  assign {shdnS, onAS, onBS, capS, otS, porS, rstOkS, uvS, ovS} = syncIn;

  psup_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .shdnS        (shdnS),
    .onAS         (onAS),
    .onBS         (onBS),
    .capS         (capS),
    .otS          (otS),
    .porS         (porS),
    .seqSel       (seqSel),
    .rstOkS       (rstOkS),
    .uvS          (uvS),
    .ovS          (ovS),
    .pgDone       (pgDone),
    .uvArmed      (uvArmed),
    .ctl          (ctl),
    .opMode       (opMode),
    .chEn         (chEn),
    .sysResetN    (sysResetN),
    .latchedOff   (latchedOff),
    .lowSideForce (lowSideForce)
  );

  psup_timers #(.PG_DELAY(PG_DELAY), .UV_ARM(UV_ARM)) u_timers (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .ctl     (ctl),
    .pgDone  (pgDone),
    .uvArmed (uvArmed)
  );

endmodule

// File: tb/psu_supervisor_test.sv
`timescale 1ns/1ps
module psu_supervisor_test;

  localparam int PG = 24;
  localparam int UV = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       shdnN = 1'b0, onA = 1'b0, onB = 1'b0, capAbove = 1'b0, tick = 1'b0;
  logic [1:0] seqSel = 2'b00, rstOkFlag = 2'b00, uvFlag = 2'b00, ovFlag = 2'b00;
  logic       otFlag = 1'b0, porFlag = 1'b0;
  logic [1:0] opMode, chEn;
  logic       sysResetN, latchedOff, lowSideForce;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  psu_supervisor #(.PG_DELAY(PG), .UV_ARM(UV)) uut (
    .clk(clk), .rstN(rstN), .shdnN(shdnN), .onA(onA), .onB(onB), .seqSel(seqSel),
    .capAbove(capAbove), .tick(tick), .rstOkFlag(rstOkFlag), .uvFlag(uvFlag),
    .ovFlag(ovFlag), .otFlag(otFlag), .porFlag(porFlag), .opMode(opMode),
    .chEn(chEn), .sysResetN(sysResetN), .latchedOff(latchedOff),
    .lowSideForce(lowSideForce)
  );

  // one tick every fourth clock, driven away from the active edge
  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc++;
      tick = (tc % 4 == 0);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitTicks(input int n);
    int seen = 0;
    while (seen < n) begin
      @(negedge clk);
      if (tick) seen++;
    end
  endtask

  task automatic pulseUv(input logic [1:0] v);
    uvFlag = v; waitCyc(3); uvFlag = 2'b00;
  endtask

  task automatic pulseOv(input logic [1:0] v);
    ovFlag = v; waitCyc(3); ovFlag = 2'b00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(4);
    // reset state (R1)
    check("R1 reset mode", opMode, 0);
    check("R1 reset chEn", chEn, 0);
    check("R6 reset sysResetN", sysResetN, 0);
    check("R12 reset latch", latchedOff, 0);

    // R1/R2/R3: exhaustive sweep of shutdown, on inputs, over-temperature
    rstOkFlag = 2'b11;
    for (int s = 0; s < 32; s++) begin
      logic sh, a, b, ot, act;
      int   expEn, expMode;
      sh = s[0]; a = s[1]; b = s[2]; ot = s[3];
      seqSel = s[4] ? 2'b11 : 2'b00;
      shdnN = sh; onA = a; onB = b; otFlag = ot;
      waitCyc(6);
      act = sh & ~ot;
      expEn = act ? int'({b, a}) : 0;
      expMode = !act ? 0 : (expEn != 0 ? 2 : 1);
      check(ot ? "R2 sweep chEn" : "R3 sweep chEn", chEn, expEn);
      check(ot ? "R2 sweep mode" : "R1 sweep mode", opMode, expMode);
    end

    // R6/R7/R9: power-good delay, independent mode
    seqSel = 2'b00; otFlag = 0; shdnN = 1; onA = 0; onB = 0;
    waitCyc(6);
    onA = 1;
    waitTicks(PG - 2);
    check("R6 before delay", sysResetN, 0);
    waitTicks(4); waitCyc(3);
    check("R6 after delay", sysResetN, 1);
    rstOkFlag = 2'b10; waitCyc(4);
    check("R9 drop pulls low", sysResetN, 0);
    rstOkFlag = 2'b11; waitCyc(4);
    check("R9 return no recount", sysResetN, 1);
    rstOkFlag = 2'b01; waitCyc(4);
    check("R7 B flag ignored", sysResetN, 1);
    rstOkFlag = 2'b11;
    onA = 0; onB = 1;
    waitTicks(PG + 4);
    check("R7 only B runs", sysResetN, 0);
    check("R3 only B chEn", chEn, 2);

    // R4: B first, capacitor then A
    onB = 0; waitCyc(6);
    seqSel = 2'b01; waitCyc(2);
    onA = 1; waitCyc(6);
    check("R4 B on edge", chEn, 2);
    capAbove = 1; waitCyc(6);
    check("R4 A on cap", chEn, 3);
    waitTicks(PG + 4); waitCyc(3);
    check("R8 both good", sysResetN, 1);
    rstOkFlag = 2'b01; waitCyc(4);
    check("R8 B not good", sysResetN, 0);
    rstOkFlag = 2'b11; waitCyc(4);
    check("R8 B good again", sysResetN, 1);
    onA = 0; capAbove = 0; waitCyc(6);
    check("R4 release", chEn, 0);
    shdnN = 0; onA = 1; waitCyc(6);
    shdnN = 1; waitCyc(6);
    check("R4 level no start", chEn, 0);
    onA = 0; waitCyc(6); onA = 1; waitCyc(6);
    check("R4 restart edge", chEn, 2);

    // R5: A first
    onA = 0; waitCyc(6);
    seqSel = 2'b10; waitCyc(2);
    onA = 1; waitCyc(6);
    check("R5 A on edge", chEn, 1);
    onB = 1; waitCyc(6);
    check("R5 onB ignored", chEn, 1);
    capAbove = 1; waitCyc(6);
    check("R5 B on cap", chEn, 3);
    onA = 0; onB = 0; capAbove = 0; waitCyc(6);
    seqSel = 2'b00; waitCyc(2);

    // R10: under-voltage arming
    onA = 1; waitCyc(6);
    pulseUv(2'b01); waitCyc(4);
    check("R10 unarmed latch", latchedOff, 0);
    check("R10 unarmed chEn", chEn, 1);
    waitTicks(UV + 2);
    pulseUv(2'b10); waitCyc(5);
    check("R10 disabled channel", latchedOff, 0);
    pulseUv(2'b01); waitCyc(4);
    check("R10 armed latch", latchedOff, 1);
    check("R10 armed chEn", chEn, 0);
    check("R10 no low-side", lowSideForce, 0);
    onA = 0; waitCyc(5);
    check("R12 onA fall clears", latchedOff, 0);
    onA = 1; waitCyc(6);
    check("R12 restart chEn", chEn, 1);

    // R11/R12: over-voltage latch and its release causes
    pulseOv(2'b10); waitCyc(4);
    check("R11 ov latch", latchedOff, 1);
    check("R11 ov low-side", lowSideForce, 1);
    check("R11 ov chEn", chEn, 0);
    check("R11 ov mode", opMode, 1);
    waitCyc(10);
    check("R12 latch persists", latchedOff, 1);
    shdnN = 0; waitCyc(5); shdnN = 1; waitCyc(6);
    check("R12 shdn clears", latchedOff, 0);
    check("R12 shdn clears ls", lowSideForce, 0);
    check("R12 shdn restart", chEn, 1);
    pulseOv(2'b01); waitCyc(4);
    check("R11 ov A latch", latchedOff, 1);
    porFlag = 1; waitCyc(5);
    check("R12 por shutdown", opMode, 0);
    porFlag = 0; waitCyc(6);
    check("R12 por clears", latchedOff, 0);
    check("R12 por restart", chEn, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule